// File: doc/BRIEF.md
# Hexagonal-Lattice Multilevel Space-Vector Calculator

This block turns one space-vector reference into the switching data for a multilevel three-phase inverter. The reference is given as a modulation depth and an angle. The angle is a code in which one 60° sector spans 128 steps, so a full turn spans 768 steps. The block splits the angle into a sector number and a residual. It looks up the sine and cosine of the quantized residual in a quarter-wave table and scales both by the depth. It then expresses the reference in a skewed lattice whose axes sit 60° apart, with one lattice unit equal to 16384 codes.

The lower-left lattice point is found by truncating both coordinates. A test on the two fractional parts then decides whether the reference lies in the lower or the upper small triangle of that cell. From this the block produces the global triangle index, the dwell time of each of the three corner vectors, and the phase-level triple of each corner for the actual sector. The dwell times are normalized so that one modulation period equals 16384.

A host pulses `start` with the inputs. The results appear together with a one-cycle `done` pulse and are held until the next result. A new request may be issued on every clock.

Top module: `svpwm_hex_calc`

## Requirements
- R1: `sector` equals `theta` divided by 128, truncated. The residual is `theta` mod 128. `theta` must be below 768 and `mdepth` at most 32768, which stands for a depth of 1.0.
- R2: Table entry i (i = 0..64) is 32768 + round(32767·sin(i·90°/64)). The residual is quantized to j = floor(residual/3). The sine magnitude is entry j − 32768. The cosine magnitude is entry 64−j − 32768. Every entry read is at least 32768.
- R3: alpha = floor(mdepth·cosmag/32768) and beta = floor(mdepth·sinmag/32768). With q = floor(beta·37837/65536), the lattice coordinates are Vg = alpha − q and Vh = 2q. Both are non-negative.
- R4: g = floor(Vg/16384) and h = floor(Vh/16384). fg and fh are the remainders. The reference lies in the upper triangle only when fg + fh > 16384; equality counts as lower.
- R5: `tri_idx` = 4·sector + g + h + 1 for the lower triangle and 4·sector + g + h + 2 for the upper triangle.
- R6: In the lower triangle the corners in slots 0, 1 and 2 are (g,h), (g+1,h) and (g,h+1). Their dwell times are 16384 − fg − fh, fg and fh.
- R7: In the upper triangle the corners in slots 0, 1 and 2 are (g+1,h), (g,h+1) and (g+1,h+1). Their dwell times are 16384 − fh, 16384 − fg and fg + fh − 16384.
- R8: On every result, the three dwell times add up to exactly 16384.
- R9: Each state output packs phase A in bits [8:6], B in [5:3] and C in [2:0]. A corner (x,y) gives (x+y, y, 0) in sector 0 and (x, x+y, 0) in sector 1.
- R10: Sector 2 is the sector-0 triple rotated right by one phase, (C,A,B). Sector 4 is that rotation applied twice. Sectors 3 and 5 apply the same rotations to the sector-1 triple.
- R11: `done` rises exactly 5 clocks after the edge that samples `start`. It rises once per request, including when requests arrive on consecutive cycles.
- R12: After reset, `done` is low and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; inputs are sampled with it |
| theta | input | 10 | Angle code, 128 steps per 60° |
| mdepth | input | 16 | Modulation depth, 32768 = 1.0 |
| done | output | 1 | One-cycle result strobe |
| sector | output | 3 | Sector number 0..5 |
| tri_idx | output | 6 | Global small-triangle index |
| ton0 | output | 16 | Dwell time of corner slot 0 |
| ton1 | output | 16 | Dwell time of corner slot 1 |
| ton2 | output | 16 | Dwell time of corner slot 2 |
| state0 | output | 9 | Phase-level triple of corner slot 0 |
| state1 | output | 9 | Phase-level triple of corner slot 1 |
| state2 | output | 9 | Phase-level triple of corner slot 2 |

## Verification
Two events often land on the same clock: a new request is accepted while an earlier request's result is being issued on `done`. The bench provokes this by streaming every angle code, under five depths, on back-to-back cycles with only occasional idle gaps. Each result is matched in order against an arithmetic model of the requirements. Each `done` is also checked to arrive exactly five clocks after its own request, which shows that no in-flight result is lost, merged or reordered.

// File: rtl/svpwm_hex_pkg.sv
package svpwm_hex_pkg;
  localparam int COORD_W = 4;
  localparam int ST_W    = 3;
  localparam int PHASES  = 3;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
  } vtx_t;

  typedef logic [PHASES*ST_W-1:0] triple_t;

  // Rotate (A,B,C) to (C,A,B).
  function automatic triple_t rot_right(input triple_t t);
    return {t[ST_W-1:0], t[PHASES*ST_W-1:ST_W]};
  endfunction
endpackage

// File: rtl/svpwm_sine_rom.sv
module svpwm_sine_rom #(
  parameter int TBL_N = 64,
  parameter int VAL_W = 16,
  localparam int IDX_W = $clog2(TBL_N + 1)
) (
  input  logic [IDX_W-1:0] idx_sin,
  input  logic [IDX_W-1:0] idx_cos,
  output logic [VAL_W-1:0] val_sin,
  output logic [VAL_W-1:0] val_cos
);
  localparam int MID = 1 << (VAL_W - 1);
  localparam int AMP = MID - 1;

  function automatic int entry(input int i);
    real a;
    a = (3.14159265358979 * i) / (2.0 * TBL_N);
    return MID + $rtoi(AMP * $sin(a) + 0.5);
  endfunction

  logic [VAL_W-1:0] tbl [TBL_N+1];

  for (genvar i = 0; i <= TBL_N; i++) begin : g_tbl
    assign tbl[i] = VAL_W'(entry(i));
  end

  assign val_sin = tbl[idx_sin];
  assign val_cos = tbl[idx_cos];
endmodule

// File: rtl/svpwm_lattice.sv
module svpwm_lattice import svpwm_hex_pkg::*; #(
  parameter int FRAC   = 14,
  parameter int VW     = FRAC + COORD_W,
  parameter int TIME_W = 16,
  parameter int TRI_W  = 6
) (
  input  logic signed [VW-1:0] vg,
  input  logic signed [VW-1:0] vh,
  output vtx_t                 vtx [PHASES],
  output logic [TIME_W-1:0]    ton [PHASES],
  output logic [TRI_W-1:0]     tri_local
);
  localparam int FULL = 1 << FRAC;

  logic [COORD_W-1:0] g, h, g1, h1;
  logic [FRAC-1:0]    fg, fh;
  logic [FRAC:0]      fsum;
  logic               upper;

  always_comb begin
    g     = COORD_W'(vg[VW-1:FRAC]);
    h     = COORD_W'(vh[VW-1:FRAC]);
    fg    = vg[FRAC-1:0];
    fh    = vh[FRAC-1:0];
    g1    = g + COORD_W'(1);
    h1    = h + COORD_W'(1);
    fsum  = {1'b0, fg} + {1'b0, fh};
    upper = fsum > (FRAC+1)'(FULL);
    tri_local = TRI_W'(g) + TRI_W'(h) + TRI_W'(1) + TRI_W'(upper);
    if (!upper) begin
      vtx[0] = '{x: g,  y: h};
      vtx[1] = '{x: g1, y: h};
      vtx[2] = '{x: g,  y: h1};
      ton[0] = TIME_W'(FULL) - TIME_W'(fsum);
      ton[1] = TIME_W'(fg);
      ton[2] = TIME_W'(fh);
    end else begin
      vtx[0] = '{x: g1, y: h};
      vtx[1] = '{x: g,  y: h1};
      vtx[2] = '{x: g1, y: h1};
      ton[0] = TIME_W'(FULL) - TIME_W'(fh);
      ton[1] = TIME_W'(FULL) - TIME_W'(fg);
      ton[2] = TIME_W'(fsum) - TIME_W'(FULL);
    end
  end
endmodule

// File: rtl/svpwm_state_map.sv
module svpwm_state_map import svpwm_hex_pkg::*; (
  input  logic [2:0] sector,
  input  vtx_t       vtx,
  output triple_t    triple
);
  logic [ST_W-1:0] xx, yy, xs;
  triple_t         base0, base1;

  always_comb begin
    xx    = ST_W'(vtx.x);
    yy    = ST_W'(vtx.y);
    xs    = xx + yy;
    base0 = {xs, yy, ST_W'(0)};
    base1 = {xx, xs, ST_W'(0)};
    case (sector)
      3'd0:    triple = base0;
      3'd1:    triple = base1;
      3'd2:    triple = rot_right(base0);
      3'd3:    triple = rot_right(base1);
      3'd4:    triple = rot_right(rot_right(base0));
      3'd5:    triple = rot_right(rot_right(base1));
      default: triple = '0;
    endcase
  end
endmodule

// File: rtl/svpwm_hex_calc.sv
module svpwm_hex_calc import svpwm_hex_pkg::*; #(
  parameter int RES_W  = 7,
  parameter int TBL_N  = 64,
  parameter int VAL_W  = 16,
  parameter int M_W    = 16,
  parameter int FRAC   = 14,
  parameter int TIME_W = 16,
  parameter int TRI_W  = 6,
  parameter int INV_R3 = 37837,
  parameter int INV_SH = 16,
  localparam int SECT_W = 3,
  localparam int TH_W   = RES_W + SECT_W,
  localparam int STW    = PHASES * ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TH_W-1:0]   theta,
  input  logic [M_W-1:0]    mdepth,
  output logic              done,
  output logic [SECT_W-1:0] sector,
  output logic [TRI_W-1:0]  tri_idx,
  output logic [TIME_W-1:0] ton0,
  output logic [TIME_W-1:0] ton1,
  output logic [TIME_W-1:0] ton2,
  output logic [STW-1:0]    state0,
  output logic [STW-1:0]    state1,
  output logic [STW-1:0]    state2
);
  localparam int STEP   = (3 << (RES_W - 1)) / TBL_N;
  localparam int IDX_W  = $clog2(TBL_N + 1);
  localparam int MAG_W  = VAL_W - 1;
  localparam int VW     = FRAC + COORD_W;
  localparam int PA_W   = M_W + MAG_W;
  localparam int PQ_W   = M_W + INV_SH + 1;
  localparam int LAT    = 5;
  localparam int TH_MAX = 6 << RES_W;
  localparam int M_ONE  = 1 << (M_W - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  // stage A: sector split and table index
  logic              a_vld;
  logic [SECT_W-1:0] a_sec, a_sec_n;
  logic [IDX_W-1:0]  a_idx, a_idx_n;
  logic [M_W-1:0]    a_m;

  always_comb begin
    a_sec_n = theta[TH_W-1:RES_W];
    a_idx_n = IDX_W'(32'(theta[RES_W-1:0]) / STEP);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_vld <= 1'b0;
      a_sec <= '0;
      a_idx <= '0;
      a_m   <= '0;
    end else begin
      a_vld <= start;
      if (start) begin
        a_sec <= a_sec_n;
        a_idx <= a_idx_n;
        a_m   <= mdepth;
      end
    end
  end

  // quarter-wave table
  logic [IDX_W-1:0] idx_cos;
  logic [VAL_W-1:0] val_sin, val_cos;
  assign idx_cos = IDX_W'(TBL_N) - a_idx;

  svpwm_sine_rom #(.TBL_N(TBL_N), .VAL_W(VAL_W)) u_rom (
    .idx_sin (a_idx),
    .idx_cos (idx_cos),
    .val_sin (val_sin),
    .val_cos (val_cos)
  );

  // stage B: magnitudes
  logic              b_vld;
  logic [SECT_W-1:0] b_sec;
  logic [M_W-1:0]    b_m;
  logic [MAG_W-1:0]  b_sin, b_cos;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      b_vld <= 1'b0;
      b_sec <= '0;
      b_m   <= '0;
      b_sin <= '0;
      b_cos <= '0;
    end else begin
      b_vld <= a_vld;
      if (a_vld) begin
        b_sec <= a_sec;
        b_m   <= a_m;
        b_sin <= val_sin[MAG_W-1:0];
        b_cos <= val_cos[MAG_W-1:0];
      end
    end
  end

  // stage C: orthogonal components scaled by depth
  logic              c_vld;
  logic [SECT_W-1:0] c_sec;
  logic [M_W-1:0]    c_alpha, c_beta, alpha_n, beta_n;
  logic [PA_W-1:0]   prod_a, prod_b;

  always_comb begin
    prod_a  = PA_W'(b_m) * PA_W'(b_cos);
    prod_b  = PA_W'(b_m) * PA_W'(b_sin);
    alpha_n = prod_a[M_W-1 +: M_W];
    beta_n  = prod_b[M_W-1 +: M_W];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      c_vld   <= 1'b0;
      c_sec   <= '0;
      c_alpha <= '0;
      c_beta  <= '0;
    end else begin
      c_vld <= b_vld;
      if (b_vld) begin
        c_sec   <= b_sec;
        c_alpha <= alpha_n;
        c_beta  <= beta_n;
      end
    end
  end

  // stage D: skewed-lattice coordinates
  logic                 d_vld;
  logic [SECT_W-1:0]    d_sec;
  logic signed [VW-1:0] d_vg, d_vh, vg_n, vh_n;
  logic [PQ_W-1:0]      prod_q;
  logic [M_W-1:0]       q_n;

  always_comb begin
    prod_q = PQ_W'(c_beta) * PQ_W'(INV_R3);
    q_n    = prod_q[INV_SH +: M_W];
    vg_n   = signed'(VW'(c_alpha)) - signed'(VW'(q_n));
    vh_n   = signed'(VW'(q_n) << 1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      d_vld <= 1'b0;
      d_sec <= '0;
      d_vg  <= '0;
      d_vh  <= '0;
    end else begin
      d_vld <= c_vld;
      if (c_vld) begin
        d_sec <= c_sec;
        d_vg  <= vg_n;
        d_vh  <= vh_n;
      end
    end
  end

  // stage E: triangle, dwell times, phase states
  vtx_t              vtx   [PHASES];
  logic [TIME_W-1:0] ton_n [PHASES];
  triple_t           st_n  [PHASES];
  logic [TRI_W-1:0]  tri_local, tri_n;

  svpwm_lattice #(.FRAC(FRAC), .VW(VW), .TIME_W(TIME_W), .TRI_W(TRI_W)) u_lat (
    .vg        (d_vg),
    .vh        (d_vh),
    .vtx       (vtx),
    .ton       (ton_n),
    .tri_local (tri_local)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_map
    svpwm_state_map u_map (
      .sector (d_sec),
      .vtx    (vtx[p]),
      .triple (st_n[p])
    );
  end

  assign tri_n = TRI_W'({d_sec, 2'b00}) + tri_local;

  logic              done_q;
  logic [SECT_W-1:0] sec_q;
  logic [TRI_W-1:0]  tri_q;
  logic [TIME_W-1:0] ton_q [PHASES];
  triple_t           st_q  [PHASES];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      done_q <= 1'b0;
      sec_q  <= '0;
      tri_q  <= '0;
      for (int p = 0; p < PHASES; p++) begin
        ton_q[p] <= '0;
        st_q[p]  <= '0;
      end
    end else begin
      done_q <= d_vld;
      if (d_vld) begin
        sec_q <= d_sec;
        tri_q <= tri_n;
        for (int p = 0; p < PHASES; p++) begin
          ton_q[p] <= ton_n[p];
          st_q[p]  <= st_n[p];
        end
      end
    end
  end

  assign done    = done_q;
  assign sector  = sec_q;
  assign tri_idx = tri_q;
  assign ton0    = ton_q[0];
  assign ton1    = ton_q[1];
  assign ton2    = ton_q[2];
  assign state0  = st_q[0];
  assign state1  = st_q[1];
  assign state2  = st_q[2];

  // R1
  input_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    start |-> (32'(theta) < TH_MAX) && (32'(mdepth) <= M_ONE));

  // R2
  table_offset_chk: assert property (@(posedge clk) disable iff (!rst_s)
    a_vld |-> val_sin[VAL_W-1] && val_cos[VAL_W-1]);

  // R3
  lattice_sign_chk: assert property (@(posedge clk) disable iff (!rst_s)
    d_vld |-> !d_vg[VW-1] && !d_vh[VW-1]);

  // R5
  tri_base_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> tri_idx > TRI_W'({sector, 2'b00}));

  // R8
  ton_sum_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (17'(ton0) + 17'(ton1) + 17'(ton2)) == 17'(1 << FRAC));

  // R11
  done_lat_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> $past(start, LAT));
endmodule

// File: tb/svpwm_hex_calc_tb.sv
module svpwm_hex_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  theta = '0;
  logic [15:0] mdepth = '0;
  logic        done;
  logic [2:0]  sector;
  logic [5:0]  tri_idx;
  logic [15:0] ton0, ton1, ton2;
  logic [8:0]  state0, state1, state2;

  svpwm_hex_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .theta(theta), .mdepth(mdepth),
    .done(done), .sector(sector), .tri_idx(tri_idx),
    .ton0(ton0), .ton1(ton1), .ton2(ton2),
    .state0(state0), .state1(state1), .state2(state2)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit fin    = 1'b0;
  int tbl [65];
  int e_sec [4096];
  int e_tri [4096];
  int e_up  [4096];
  int e_iss [4096];
  int e_t   [4096][3];
  int e_st  [4096][3];
  int wr = 0;
  int rd = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pack3(input int a, input int b, input int c);
    return ((a & 7) << 6) | ((b & 7) << 3) | (c & 7);
  endfunction

  // R9 R10 phase triples per sector
  function automatic int stp(input int s, input int x, input int y);
    case (s)
      0: return pack3(x + y, y, 0);
      1: return pack3(x, x + y, 0);
      2: return pack3(0, x + y, y);
      3: return pack3(0, x, x + y);
      4: return pack3(y, 0, x + y);
      default: return pack3(x + y, 0, x);
    endcase
  endfunction

  task automatic issue(input int th, input int mm);
    int sec, r, j, sv, cv, g, h, fg, fh, up;
    longint al, be, q, vg, vh;
    int vx [3];
    int vy [3];
    sec = th / 128;
    r   = th % 128;
    j   = r / 3;
    sv  = tbl[j] - 32768;
    cv  = tbl[64 - j] - 32768;
    al  = (longint'(mm) * cv) >>> 15;
    be  = (longint'(mm) * sv) >>> 15;
    q   = (be * 37837) >>> 16;
    vg  = al - q;
    vh  = 2 * q;
    g   = int'(vg >>> 14);
    h   = int'(vh >>> 14);
    fg  = int'(vg) - g * 16384;
    fh  = int'(vh) - h * 16384;
    up  = (fg + fh > 16384) ? 1 : 0;
    e_sec[wr] = sec;
    e_tri[wr] = 4 * sec + g + h + 1 + up;
    e_up[wr]  = up;
    e_iss[wr] = cyc;
    if (up == 0) begin
      vx[0] = g;     vy[0] = h;     e_t[wr][0] = 16384 - fg - fh;
      vx[1] = g + 1; vy[1] = h;     e_t[wr][1] = fg;
      vx[2] = g;     vy[2] = h + 1; e_t[wr][2] = fh;
    end else begin
      vx[0] = g + 1; vy[0] = h;     e_t[wr][0] = 16384 - fh;
      vx[1] = g;     vy[1] = h + 1; e_t[wr][1] = 16384 - fg;
      vx[2] = g + 1; vy[2] = h + 1; e_t[wr][2] = fg + fh - 16384;
    end
    for (int p = 0; p < 3; p++) e_st[wr][p] = stp(sec, vx[p], vy[p]);
    wr++;
    start  = 1'b1;
    theta  = 10'(th);
    mdepth = 16'(mm);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // result checker
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (rd >= wr) begin
        chk(1'b0, "R11 spurious done", rd, wr);
      end else begin
        int act [3];
        int ast [3];
        act[0] = int'(ton0); act[1] = int'(ton1); act[2] = int'(ton2);
        ast[0] = int'(state0); ast[1] = int'(state1); ast[2] = int'(state2);
        chk(cyc - e_iss[rd] == 5, "R11 latency", cyc - e_iss[rd], 5);
        chk(int'(sector) == e_sec[rd], "R1 sector", int'(sector), e_sec[rd]);
        chk(int'(tri_idx) == e_tri[rd], "R5 triangle (R4 side)", int'(tri_idx), e_tri[rd]);
        for (int p = 0; p < 3; p++) begin
          chk(act[p] == e_t[rd][p], e_up[rd] != 0 ? "R7 upper dwell (R2 R3)" : "R6 lower dwell (R2 R3)",
              act[p], e_t[rd][p]);
          chk(ast[p] == e_st[rd][p], e_sec[rd] < 2 ? "R9 state" : "R10 rotated state",
              ast[p], e_st[rd][p]);
        end
        chk(act[0] + act[1] + act[2] == 16384, "R8 dwell sum", act[0] + act[1] + act[2], 16384);
        rd++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int mlist [5];
    mlist[0] = 0; mlist[1] = 9830; mlist[2] = 16384; mlist[3] = 24576; mlist[4] = 32768;
    for (int i = 0; i <= 64; i++)
      tbl[i] = 32768 + $rtoi(32767 * $sin((3.14159265358979 * i) / (2.0 * 64)) + 0.5);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(done == 1'b0, "R12 done", int'(done), 0);
    chk(sector == 3'd0, "R12 sector", int'(sector), 0);
    chk(tri_idx == 6'd0, "R12 tri_idx", int'(tri_idx), 0);
    chk(ton0 == 16'd0 && ton1 == 16'd0 && ton2 == 16'd0, "R12 dwell", int'(ton0), 0);
    chk(state0 == 9'd0 && state1 == 9'd0 && state2 == 9'd0, "R12 state", int'(state0), 0);

    // R2 R6 R9 hand-computed: full depth, zero residual, sector 0
    issue(0, 32768);
    idle(8);
    chk(tri_idx == 6'd2, "R2 tri at 0deg", int'(tri_idx), 2);
    chk(ton0 == 16'd1 && ton1 == 16'd16383 && ton2 == 16'd0, "R2 R6 dwell at 0deg", int'(ton1), 16383);
    chk(state0 == 9'd64 && state1 == 9'd128 && state2 == 9'd136, "R9 sector0 states", int'(state2), 136);

    // R9 sector 1, same residual
    issue(128, 32768);
    idle(8);
    chk(sector == 3'd1 && tri_idx == 6'd6, "R5 tri sector1", int'(tri_idx), 6);
    chk(state0 == 9'd72 && state1 == 9'd144 && state2 == 9'd80, "R9 sector1 states", int'(state2), 80);

    // full angle sweep, back-to-back with sparse gaps
    for (int k = 0; k < 5; k++) begin
      for (int th = 0; th < 768; th++) begin
        issue(th, mlist[k]);
        if (th % 7 == 6) idle(1);
      end
    end
    idle(12);
    chk(rd == wr, "R11 result count", rd, wr);

    summary();
    fin = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired rd=%0d expected=%0d", rd, wr);
      summary();
      $finish;
    end
  end
endmodule